// File: doc/BRIEF.md
# Audio Word-Select Transition Counter with Event Snapshot

This block measures how many audio words pass over a long interval. It counts every transition of the audio word-select line, rising or falling. The count register is 10 bits wide by default. When a chosen event arrives, the block copies the running count into a snapshot register and restarts the count in that same clock edge. Software can divide the snapshot by the known spacing of the events to work out the average sample rate. A typical case is an adaptive isochronous USB endpoint that is retriggered on every 1 ms start-of-frame.

A 2-bit select input chooses the hardware event. Code 0 turns hardware events off. Code 1 picks the frame-start pulse, code 2 picks the timer compare pulse, and code 3 picks any transition on a general I/O pin. A write strobe from software does the same copy-and-restart whatever the select value is. The word-select line and the I/O pin are asynchronous, so each passes through a synchroniser before edge detection. The two pulse events are already synchronous to the system clock. The snapshot is presented as a 2-bit high part and an 8-bit low part.

Top module: `awc_word_counter`

## Requirements
- R1: After reset, the snapshot reads 0 and the running count is 0.
- R2: Each transition of the word-select line adds one to the running count, whether it is a rise or a fall.
- R3: The running count stops at 1023 (all ones) and does not wrap on later transitions.
- R4: With select code 1, a one-cycle frame-start pulse copies the count into the snapshot and clears the count.
- R5: With select code 2, a one-cycle timer compare pulse copies the count into the snapshot and clears the count.
- R6: With select code 3, a transition of the I/O pin in either direction copies the count into the snapshot and clears the count. The pin is synchronised first.
- R7: With select code 0, none of the three hardware events changes the snapshot or the count.
- R8: A software write strobe copies the count into the snapshot and clears the count under every select code.
- R9: If a word-select transition and a trigger fall in the same cycle, the snapshot takes the count from before that transition and the count restarts at 1.
- R10: The snapshot holds its value between triggers. An event that the select code does not pick has no effect.
- R11: The snapshot value is split across the outputs: bits 9:8 appear on the high output and bits 7:0 on the low output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ws_i | input | 1 | Audio word-select line, asynchronous |
| frame_evt_i | input | 1 | Frame-start pulse, one cycle, synchronous (select code 1) |
| timer_evt_i | input | 1 | Timer compare pulse, one cycle, synchronous (select code 2) |
| pin_i | input | 1 | General I/O pin, asynchronous, either edge triggers (select code 3) |
| trig_sel_i | input | 2 | Hardware trigger select: 0 none, 1 frame, 2 timer, 3 pin |
| cnt_wr_i | input | 1 | Software write strobe: snapshot and clear |
| snap_hi_o | output | 2 | Snapshot bits 9:8 |
| snap_lo_o | output | 8 | Snapshot bits 7:0 |

## Verification
The bench builds the block with its default parameters: a 10-bit count and two synchroniser stages. With these values, saturation at 1023 can be reached in about a thousand word-select toggles, one toggle per cycle, and the full high/low split of the snapshot is exercised. The two-stage synchroniser fixes the latency of the word-select path and of the pin path at three cycles. The bench uses that latency to land a word-select transition and a write strobe on exactly the same edge.

// File: rtl/awc_pkg.sv
package awc_pkg;

   // Hardware trigger select codes; the code order fixes which source is used
   typedef enum logic [1:0] {
      TRG_NONE  = 2'd0,
      TRG_FRAME = 2'd1,
      TRG_TIMER = 2'd2,
      TRG_PIN   = 2'd3
   } trig_sel_e;

   localparam int unsigned LO_BYTE_W = 8;

   // Saturating increment helper
   function automatic logic [31:0] sat_next(input logic [31:0] cur,
                                           input logic [31:0] top);
      return (cur >= top) ? top : cur + 32'd1;
   endfunction

endpackage

// File: rtl/awc_sync.sv
module awc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad
         $error("awc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/awc_toggle_det.sv
module awc_toggle_det #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic toggle_o
);

   logic synced;
   logic prev_q;

   awc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (async_i),
      .q_o    (synced)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= synced;
   end

   assign toggle_o = synced ^ prev_q;

endmodule

// File: rtl/awc_trig_sel.sv
module awc_trig_sel #(
   parameter int unsigned   NUM_SRC     = 3,
   parameter int unsigned   SEL_W       = 2,
   parameter int unsigned   SYNC_STAGES = 2,
   parameter logic [NUM_SRC-1:0] ASYNC_MASK = '0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic               sw_wr_i,
   output logic               fire_o
);

   generate
      if ((1 << SEL_W) < NUM_SRC + 1) begin : g_bad_sel
         $error("awc_trig_sel: SEL_W too narrow for NUM_SRC");
      end
   endgenerate

   logic [NUM_SRC-1:0] evt;

   // Each source is either a clean synchronous pulse or an async level whose edges count
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (ASYNC_MASK[i]) begin : g_async
         awc_toggle_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .async_i  (src_i[i]),
            .toggle_o (evt[i])
         );
      end else begin : g_pulse
         assign evt[i] = src_i[i];
      end
   end

   logic hw_fire;

   always_comb begin
      hw_fire = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel_i == SEL_W'(i + 1)) hw_fire = evt[i];
      end
   end

   assign fire_o = hw_fire | sw_wr_i;

endmodule

// File: rtl/awc_counter.sv
module awc_counter #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             step_i,
   input  logic             fire_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] snap_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, snap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         snap_q <= '0;
      end else if (fire_i) begin
         snap_q <= cnt_q;
         cnt_q  <= step_i ? CNT_W'(1) : '0;
      end else if (step_i) begin
         cnt_q  <= CNT_W'(awc_pkg::sat_next(32'(cnt_q), 32'(CNT_MAX)));
      end
   end

   assign cnt_o  = cnt_q;
   assign snap_o = snap_q;

endmodule

// File: rtl/awc_word_counter.sv
module awc_word_counter #(
   parameter int unsigned CNT_W       = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                                clk_i,
   input  logic                                rst_ni,
   input  logic                                ws_i,
   input  logic                                frame_evt_i,
   input  logic                                timer_evt_i,
   input  logic                                pin_i,
   input  logic [1:0]                          trig_sel_i,
   input  logic                                cnt_wr_i,
   output logic [CNT_W-awc_pkg::LO_BYTE_W-1:0] snap_hi_o,
   output logic [awc_pkg::LO_BYTE_W-1:0]       snap_lo_o
);

   localparam int unsigned NUM_SRC = 3;
   localparam int unsigned LO_W    = awc_pkg::LO_BYTE_W;
   localparam int unsigned HI_W    = CNT_W - LO_W;
   // Only the pin source is asynchronous (bit index = select code - 1)
   localparam logic [NUM_SRC-1:0] ASYNC_MASK = 3'b100;

   generate
      if (CNT_W <= LO_W || CNT_W > 16) begin : g_bad_w
         $error("awc_word_counter: CNT_W must be 9..16");
      end
   endgenerate

   logic             ws_edge;
   logic             trig_fire;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] snap_q;

   awc_toggle_det #(.SYNC_STAGES(SYNC_STAGES)) u_ws_det (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .async_i  (ws_i),
      .toggle_o (ws_edge)
   );

   awc_trig_sel #(
      .NUM_SRC     (NUM_SRC),
      .SEL_W       (2),
      .SYNC_STAGES (SYNC_STAGES),
      .ASYNC_MASK  (ASYNC_MASK)
   ) u_trig (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .src_i   ({pin_i, timer_evt_i, frame_evt_i}),
      .sel_i   (trig_sel_i),
      .sw_wr_i (cnt_wr_i),
      .fire_o  (trig_fire)
   );

   awc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .step_i (ws_edge),
      .fire_i (trig_fire),
      .cnt_o  (cnt_q),
      .snap_o (snap_q)
   );

   assign snap_hi_o = snap_q[CNT_W-1 -: HI_W];
   assign snap_lo_o = snap_q[LO_W-1:0];

endmodule

// File: rtl/awc_word_counter_chk.sv
module awc_word_counter_chk #(
   parameter int unsigned CNT_W = 10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             ws_edge,
   input logic             trig_fire,
   input logic [1:0]       trig_sel_i,
   input logic             cnt_wr_i,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] snap_val
);

   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   // R2
   count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ws_edge && !trig_fire && cnt_q != CMAX) |=> cnt_q == $past(cnt_q) + 1'b1);

   // R3
   no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == CMAX && !trig_fire) |=> cnt_q == CMAX);

   // R8
   snap_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_fire |=> snap_val == $past(cnt_q));

   // R9
   restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_fire |=> cnt_q == ($past(ws_edge) ? CNT_W'(1) : '0));

   // R10
   snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !trig_fire |=> $stable(snap_val));

   // R7
   no_hw_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_sel_i == 2'd0 && !cnt_wr_i) |-> !trig_fire);

endmodule

bind awc_word_counter awc_word_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .ws_edge    (ws_edge),
   .trig_fire  (trig_fire),
   .trig_sel_i (trig_sel_i),
   .cnt_wr_i   (cnt_wr_i),
   .cnt_q      (cnt_q),
   .snap_val   (snap_q)
);

// File: tb/awc_word_counter_tb.sv
`timescale 1ns/1ps
module awc_word_counter_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ws = 1'b0, frame = 1'b0, timer = 1'b0, pin = 1'b0, wr = 1'b0;
   logic [1:0] sel = 2'd0;
   logic [1:0] hi;
   logic [7:0] lo;
   int         checks = 0, fails = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   awc_word_counter u_dut (
      .clk_i(clk), .rst_ni(rst_n), .ws_i(ws), .frame_evt_i(frame),
      .timer_evt_i(timer), .pin_i(pin), .trig_sel_i(sel), .cnt_wr_i(wr),
      .snap_hi_o(hi), .snap_lo_o(lo)
   );

   function automatic int snap();
      return {hi, lo};
   endfunction

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic settle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic toggle_ws(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ws = ~ws;
      end
      settle(4);
   endtask

   task automatic sw_read(output int v);
      @(negedge clk); wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      v = snap();
   endtask

   task automatic t_reset();
      check("R1 snapshot after reset", snap(), 0);
      toggle_ws(0);
      begin int v; sw_read(v); check("R1 count after reset", v, 0); end
   endtask

   task automatic t_count();
      int v;
      toggle_ws(5);
      sw_read(v); check("R2 both edges counted", v, 5);
      check("R8 read cleared count (snapshot holds)", snap(), 5);
      sw_read(v); check("R8 count cleared by write", v, 0);
      toggle_ws(677);
      sw_read(v);
      check("R11 high bits", hi, 2);
      check("R11 low byte", lo, 8'hA5);
   endtask

   task automatic t_saturate();
      int v;
      toggle_ws(1100);
      sw_read(v); check("R3 saturates at 1023", v, 1023);
      sw_read(v); check("R3 cleared after saturation", v, 0);
   endtask

   task automatic t_frame();
      int v;
      sel = 2'd1;
      toggle_ws(7);
      @(negedge clk); frame = 1'b1;
      @(negedge clk); frame = 1'b0;
      check("R4 frame snapshot", snap(), 7);
      @(negedge clk); timer = 1'b1;
      @(negedge clk); timer = 1'b0;
      check("R10 unselected timer ignored", snap(), 7);
      toggle_ws(2);
      sw_read(v); check("R4 frame cleared count", v, 2);
   endtask

   task automatic t_timer();
      int v;
      sel = 2'd2;
      toggle_ws(9);
      @(negedge clk); timer = 1'b1;
      @(negedge clk); timer = 1'b0;
      check("R5 timer snapshot", snap(), 9);
      sw_read(v); check("R5 timer cleared count", v, 0);
   endtask

   task automatic t_pin();
      int v;
      sel = 2'd3;
      toggle_ws(12);
      @(negedge clk); pin = 1'b1;
      settle(4);
      check("R6 pin rise snapshot", snap(), 12);
      toggle_ws(3);
      @(negedge clk); pin = 1'b0;
      settle(4);
      check("R6 pin fall snapshot", snap(), 3);
      sw_read(v); check("R6 pin cleared count", v, 0);
   endtask

   task automatic t_none();
      int v;
      sel = 2'd0;
      toggle_ws(3);
      @(negedge clk); frame = 1'b1;
      @(negedge clk); frame = 1'b0; timer = 1'b1;
      @(negedge clk); timer = 1'b0; pin = 1'b1;
      settle(5);
      check("R7 hardware events ignored, snapshot held", snap(), 0);
      sw_read(v); check("R7 count kept", v, 3);
   endtask

   task automatic t_same_cycle();
      int v;
      sel = 2'd0;
      sw_read(v);
      toggle_ws(4);
      @(negedge clk); ws = ~ws;
      @(negedge clk);
      @(negedge clk); wr = 1'b1;
      @(negedge clk); wr = 1'b0;
      check("R9 snapshot pre-increment", snap(), 4);
      settle(3);
      sw_read(v); check("R9 count restarted at 1", v, 1);
   endtask

   initial begin
      settle(3);
      rst_n = 1'b1;
      settle(2);
      t_reset();
      t_count();
      t_saturate();
      t_frame();
      t_timer();
      t_pin();
      t_none();
      t_same_cycle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule